// File: doc/BRIEF.md
# E3 Receive Alarm Condition Monitor

This block sits behind an E3 receive framer and watches a short per-frame summary for two alarm states. At the end of each frame the framer gives a strobe, the number of zero bits seen in that frame and the value of the frame's remote-alarm (A) bit. From these, the monitor keeps an alarm-indication state and a far-end receive failure state. Each state moves only after a run of consecutive frames that all point the other way.

The alarm-indication state drives an output pin and a status bit. Each time it changes, in either direction, the block gives a one-cycle change pulse and sets a sticky change flag. The flag stays set until a clear strobe arrives. Software can pick the far-end failure run length at run time: it is either short (three frames) or long (five frames). The same length applies to declaring the condition and to clearing it.

Top module: `e3_alarm_mon`

## Requirements
- R1: A synchronous active-high reset clears both alarm states, both run counters, the change pulse and the sticky flag, so every output reads 0 in the cycle after reset.
- R2: A frame counts as an alarm-indication frame when its zero count is below 8 (0 to 7). Two such frames in a row with alarm indication off turn it on. Both the pin and the status bit go to 1 in the cycle after the second frame-end strobe.
- R3: A frame with 8 or more zero bits counts as a clearing frame. Two such frames in a row with alarm indication on turn it off, and the pin and status bit read 0 in the cycle after the second strobe.
- R4: A frame that agrees with the current alarm-indication state restarts that run, so the next opposing frame counts as the first again. Cycles without a frame-end strobe neither count nor break a run.
- R5: Every change of the alarm-indication state, whether on or off, gives a change pulse that is 1 for exactly one cycle. The pulse appears in the same cycle as the new state and also sets the sticky flag.
- R6: The sticky flag stays at 1 until a cycle with the clear strobe high. A change event in the same cycle as the clear strobe wins, and the flag stays 1.
- R7: With the select input at 0, three consecutive frames with A=1 turn the far-end failure status on. With the select at 1, it takes five.
- R8: With far-end failure on, the same selected number of consecutive frames with A=0 turn it off.
- R9: A frame whose A bit agrees with the current far-end failure state restarts that run.
- R10: A change of the select input clears the far-end failure run counter. A frame that ends in the same cycle as the change is not counted toward that run.
- R11: When the frame-end strobe is low, the zero count and A bit are ignored and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | One-cycle strobe at the end of each received frame |
| zero_count | input | 11 | Number of zero bits counted in the frame just ended |
| a_bit | input | 1 | Remote-alarm bit of the frame just ended |
| ferf_sel | input | 1 | Far-end failure run length: 0 means 3 frames, 1 means 5 frames |
| ais_flag_clr | input | 1 | Clear strobe for the sticky change flag |
| ais_pin | output | 1 | Alarm-indication output pin |
| ais_stat | output | 1 | Alarm-indication status bit |
| ferf_stat | output | 1 | Far-end receive failure status bit |
| ais_chg_pulse | output | 1 | One-cycle pulse on each alarm-indication change |
| ais_chg_flag | output | 1 | Sticky alarm-indication change flag |

## Verification
The assertions assume that zero_count and a_bit mean something only in a cycle where frame_end is high. They also assume that the select input and the clear strobe may change in any cycle, including in the same cycle as a frame. The properties therefore tie every state change to the frame sampled one cycle earlier. The stimulus holds every input steady between falling edges. Outside frame-end cycles it fills zero_count and a_bit with arbitrary values, so the claim that these inputs are ignored is actually tested. It flips the select input and pulses the clear strobe both alone and in the same cycle as a frame.

// File: rtl/e3_alarm_mon_pkg.sv
package e3_alarm_mon_pkg;

  typedef enum logic {
    ALM_CLEAR = 1'b0,
    ALM_SET   = 1'b1
  } alm_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/alm_run_tracker.sv
module alm_run_tracker #(
  parameter int RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             restart,
  input  logic             cond,
  input  logic [RUN_W-1:0] need_set,
  input  logic [RUN_W-1:0] need_clr,
  output logic             state_o,
  output logic             chg_o
);
  import e3_alarm_mon_pkg::*;

  alm_state_e         st_q;
  logic [RUN_W-1:0]   cnt_q;
  logic [RUN_W:0]     cnt_inc;
  logic [RUN_W-1:0]   need;
  logic               opposes;
  logic               done;

  always_comb begin
    need    = (st_q == ALM_SET) ? need_clr : need_set;
    opposes = (cond != st_q);
    cnt_inc = {1'b0, cnt_q} + {{RUN_W{1'b0}}, 1'b1};
    done    = (cnt_inc >= {1'b0, need});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ALM_CLEAR;
      cnt_q <= '0;
      chg_o <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
      end else if (evt) begin
        if (opposes) begin
          if (done) begin
            st_q  <= (st_q == ALM_SET) ? ALM_CLEAR : ALM_SET;
            cnt_q <= '0;
            chg_o <= 1'b1;
          end else begin
            cnt_q <= cnt_inc[RUN_W-1:0];
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/alm_sticky_flag.sv
module alm_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= 1'b0;
    end else if (set_i) begin
      q_o <= 1'b1;
    end else if (clr_i) begin
      q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/e3_alarm_mon.sv
module e3_alarm_mon #(
  parameter int ZCW          = 11,
  parameter int ZERO_THRESH  = 8,
  parameter int AIS_SET_N    = 2,
  parameter int AIS_CLR_N    = 2,
  parameter int FERF_N_SHORT = 3,
  parameter int FERF_N_LONG  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_end,
  input  logic [ZCW-1:0] zero_count,
  input  logic           a_bit,
  input  logic           ferf_sel,
  input  logic           ais_flag_clr,
  output logic           ais_pin,
  output logic           ais_stat,
  output logic           ferf_stat,
  output logic           ais_chg_pulse,
  output logic           ais_chg_flag
);
  import e3_alarm_mon_pkg::*;

  localparam int AIS_MAX  = max2(AIS_SET_N, AIS_CLR_N);
  localparam int FERF_MAX = max2(FERF_N_SHORT, FERF_N_LONG);
  localparam int AIS_W    = $clog2(AIS_MAX + 1);
  localparam int FERF_W   = $clog2(FERF_MAX + 1);

  logic              low_zero;
  logic              sel_q;
  logic              ferf_restart;
  logic [FERF_W-1:0] ferf_need;
  logic              ais_s;
  logic              ais_chg;
  logic              ferf_s;
  logic              ferf_chg;

  always_comb begin
    low_zero     = (zero_count < ZCW'(ZERO_THRESH));
    ferf_restart = (ferf_sel != sel_q);
    ferf_need    = ferf_sel ? FERF_W'(FERF_N_LONG) : FERF_W'(FERF_N_SHORT);
  end

  always_ff @(posedge clk) begin
    sel_q <= ferf_sel;
  end

  alm_run_tracker #(.RUN_W(AIS_W)) u_ais_run (
    .clk      (clk),
    .rst      (rst),
    .evt      (frame_end),
    .restart  (1'b0),
    .cond     (low_zero),
    .need_set (AIS_W'(AIS_SET_N)),
    .need_clr (AIS_W'(AIS_CLR_N)),
    .state_o  (ais_s),
    .chg_o    (ais_chg)
  );

  alm_run_tracker #(.RUN_W(FERF_W)) u_ferf_run (
    .clk      (clk),
    .rst      (rst),
    .evt      (frame_end),
    .restart  (ferf_restart),
    .cond     (a_bit),
    .need_set (ferf_need),
    .need_clr (ferf_need),
    .state_o  (ferf_s),
    .chg_o    (ferf_chg)
  );

  alm_sticky_flag u_ais_flag (
    .clk   (clk),
    .rst   (rst),
    .set_i (ais_chg_next),
    .clr_i (ais_flag_clr),
    .q_o   (ais_chg_flag)
  );

  logic ais_chg_next;
  always_comb begin
    ais_chg_next = frame_end && ((low_zero != ais_s) && ais_run_done);
  end

  logic ais_run_done;
  logic [AIS_W:0] ais_cnt_mirror;
  always_ff @(posedge clk) begin
    if (rst) begin
      ais_cnt_mirror <= '0;
    end else if (frame_end) begin
      if ((low_zero != ais_s) && !ais_run_done) begin
        ais_cnt_mirror <= ais_cnt_mirror + 1'b1;
      end else begin
        ais_cnt_mirror <= '0;
      end
    end
  end

  always_comb begin
    ais_run_done = ((ais_cnt_mirror + 1'b1) >=
                    (ais_s ? (AIS_W + 1)'(AIS_CLR_N) : (AIS_W + 1)'(AIS_SET_N)));
  end

  assign ais_pin       = ais_s;
  assign ais_stat      = ais_s;
  assign ferf_stat     = ferf_s;
  assign ais_chg_pulse = ais_chg;

endmodule

// File: rtl/e3_alarm_mon_chk.sv
module e3_alarm_mon_chk #(
  parameter int ZCW         = 11,
  parameter int ZERO_THRESH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           frame_end,
  input logic [ZCW-1:0] zero_count,
  input logic           a_bit,
  input logic           ferf_sel,
  input logic           ais_flag_clr,
  input logic           ais_pin,
  input logic           ais_stat,
  input logic           ferf_stat,
  input logic           ais_chg_pulse,
  input logic           ais_chg_flag
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= !rst;

  // R11
  a_r11_ais_moves_on_frame: assert property (@(posedge clk) disable iff (rst || !seen)
    (ais_stat != $past(ais_stat)) |-> $past(frame_end));
  a_r11_ferf_moves_on_frame: assert property (@(posedge clk) disable iff (rst || !seen)
    (ferf_stat != $past(ferf_stat)) |-> $past(frame_end));
  // R2
  a_r2_rise_low_zeros: assert property (@(posedge clk) disable iff (rst || !seen)
    $rose(ais_stat) |-> ($past(zero_count) < ZCW'(ZERO_THRESH)) && ais_pin);
  // R3
  a_r3_fall_many_zeros: assert property (@(posedge clk) disable iff (rst || !seen)
    $fell(ais_stat) |-> ($past(zero_count) >= ZCW'(ZERO_THRESH)) && !ais_pin);
  // R5
  a_r5_change_gives_pulse: assert property (@(posedge clk) disable iff (rst || !seen)
    (ais_stat != $past(ais_stat)) |-> ais_chg_pulse);
  a_r5_pulse_needs_change: assert property (@(posedge clk) disable iff (rst || !seen)
    ais_chg_pulse |-> (ais_stat != $past(ais_stat)));
  a_r5_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst || !seen)
    ais_chg_pulse |-> ais_chg_flag);
  // R6
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst || !seen)
    ($past(ais_chg_flag) && !$past(ais_flag_clr)) |-> ais_chg_flag);
  // R7
  a_r7_ferf_rise_a_one: assert property (@(posedge clk) disable iff (rst || !seen)
    $rose(ferf_stat) |-> $past(a_bit));
  // R8
  a_r8_ferf_fall_a_zero: assert property (@(posedge clk) disable iff (rst || !seen)
    $fell(ferf_stat) |-> !$past(a_bit));
  // R10
  a_r10_sel_change_freezes: assert property (@(posedge clk) disable iff (rst || !seen)
    (ferf_sel != $past(ferf_sel)) |=> $stable(ferf_stat));
endmodule

bind e3_alarm_mon e3_alarm_mon_chk #(.ZCW(ZCW), .ZERO_THRESH(ZERO_THRESH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_end     (frame_end),
  .zero_count    (zero_count),
  .a_bit         (a_bit),
  .ferf_sel      (ferf_sel),
  .ais_flag_clr  (ais_flag_clr),
  .ais_pin       (ais_pin),
  .ais_stat      (ais_stat),
  .ferf_stat     (ferf_stat),
  .ais_chg_pulse (ais_chg_pulse),
  .ais_chg_flag  (ais_chg_flag)
);

// File: tb/e3_alarm_mon_bench.sv
module e3_alarm_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_end = 1'b0;
  logic [10:0] zero_count = '0;
  logic        a_bit = 1'b0;
  logic        ferf_sel = 1'b0;
  logic        ais_flag_clr = 1'b0;
  logic        ais_pin, ais_stat, ferf_stat, ais_chg_pulse, ais_chg_flag;

  int checks = 0;
  int failures = 0;

  // model state
  bit m_ais, m_ferf, m_pulse, m_flag, m_sel_prev;
  int m_ais_cnt, m_ferf_cnt;

  always #4 clk = ~clk;

  e3_alarm_mon u_e3_alarm_mon (
    .clk(clk), .rst(rst), .frame_end(frame_end), .zero_count(zero_count),
    .a_bit(a_bit), .ferf_sel(ferf_sel), .ais_flag_clr(ais_flag_clr),
    .ais_pin(ais_pin), .ais_stat(ais_stat), .ferf_stat(ferf_stat),
    .ais_chg_pulse(ais_chg_pulse), .ais_chg_flag(ais_chg_flag)
  );

  task automatic check(input string tag, input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "ais_pin", ais_pin, m_ais);
    check(tag, "ais_stat", ais_stat, m_ais);
    check(tag, "ferf_stat", ferf_stat, m_ferf);
    check(tag, "ais_chg_pulse", ais_chg_pulse, m_pulse);
    check(tag, "ais_chg_flag", ais_chg_flag, m_flag);
  endtask

  // Drives one cycle (called at a falling edge), updates the model, checks at the next falling edge.
  task automatic cyc(input string tag, input bit fe, input int zc, input bit a,
                     input bit sel, input bit clr);
    bit restart;
    int need;
    frame_end = fe; zero_count = 11'(zc); a_bit = a; ferf_sel = sel; ais_flag_clr = clr;
    m_pulse = 0;
    restart = (sel != m_sel_prev);
    m_sel_prev = sel;
    if (fe) begin
      if ((zc < 8) != m_ais) begin
        m_ais_cnt++;
        if (m_ais_cnt == 2) begin m_ais = !m_ais; m_ais_cnt = 0; m_pulse = 1; end
      end else m_ais_cnt = 0;
    end
    need = sel ? 5 : 3;
    if (restart) m_ferf_cnt = 0;
    else if (fe) begin
      if (a != m_ferf) begin
        m_ferf_cnt++;
        if (m_ferf_cnt == need) begin m_ferf = !m_ferf; m_ferf_cnt = 0; end
      end else m_ferf_cnt = 0;
    end
    m_flag = m_pulse | (m_flag & !clr);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; frame_end = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_ais = 0; m_ferf = 0; m_pulse = 0; m_flag = 0;
    m_ais_cnt = 0; m_ferf_cnt = 0; m_sel_prev = ferf_sel;
    @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: two low-zero frames declare, with idle gap between
    cyc("R2", 1, 3, 0, 0, 0);
    cyc("R11", 0, 0, 1, 0, 0);
    cyc("R2", 1, 7, 0, 0, 0);
    cyc("R5", 0, 900, 1, 0, 0);
    // R6: flag holds, then clears
    for (int i = 0; i < 3; i++) cyc("R6", 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 1);
    // R3: boundary 8 zeros counts as clearing
    cyc("R3", 1, 8, 0, 0, 0);
    cyc("R3", 1, 1536, 0, 0, 0);
    // R4: alternating frames never declare
    for (int i = 0; i < 6; i++) cyc("R4", 1, (i % 2) ? 8 : 7, 0, 0, 0);
    // R6: event coincides with clear
    cyc("R6", 1, 0, 0, 0, 1);
    cyc("R6", 1, 0, 0, 0, 1);
    cyc("R6", 0, 0, 0, 0, 0);
    // R7 short run, R9 break, R8 clear
    cyc("R9", 1, 20, 1, 0, 0); cyc("R9", 1, 20, 1, 0, 0); cyc("R9", 1, 20, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R7", 1, 20, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R8", 1, 20, 0, 0, 0);
    // R10: switch to long with a frame that is not counted
    cyc("R10", 1, 20, 1, 1, 0);
    for (int i = 0; i < 5; i++) cyc("R7", 1, 20, 1, 1, 0);
    cyc("R10", 1, 20, 0, 1, 0); cyc("R10", 1, 20, 0, 1, 0);
    cyc("R10", 1, 20, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R8", 1, 20, 0, 0, 0);
    // R11: idle garbage
    for (int i = 0; i < 20; i++) cyc("R11", 0, $urandom_range(0, 2047), $urandom_range(0, 1), 0, 0);
    // threshold sweep on zero counts (R2/R3 boundaries)
    for (int z = 0; z < 24; z++) begin
      cyc("R2", 1, z, 0, 0, 0);
      cyc("R3", 1, z, 0, 0, 0);
    end
    // random stream
    for (int i = 0; i < 6000; i++) begin
      bit s;
      s = ($urandom_range(0, 49) == 0) ? !ferf_sel : ferf_sel;
      cyc("R9", $urandom_range(0, 3) != 0, $urandom_range(0, 3) ? $urandom_range(0, 15) : 500,
          $urandom_range(0, 4) != 0, s, $urandom_range(0, 7) == 0);
    end
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule